// File: doc/BRIEF.md
# Edge-Coded Tape Serial Codec

This block prepares a serial bit stream for an audio tape channel and recovers it on playback. On the transmit side, each data bit is combined with a bit-rate square wave by exclusive-OR. The result is a line signal that has a transition in the middle of every bit cell, and also a transition at the cell boundary when two neighbouring bits are equal. With the bit clock held low for the first half of each cell, the line carries the data value in the first half and its inverse in the second half.

On the receive side, the playback line passes through a synchronizer. An edge compare turns every rising or falling transition into a one-cycle trigger. Each trigger starts a one-shot timer, or restarts it if it is already running. The timer lasts three quarters of a bit cell, counted in system clock cycles. When the timer runs out without a new trigger, the synchronized line level is loaded into the output data flop. During a run of equal bits, the boundary transitions keep retriggering the timer, so it never runs out and the recovered data holds. When two neighbouring bits differ, there is no boundary edge, so the timer expires a quarter cell into the new bit and captures its value.

A system clock much faster than the bit rate drives everything. The nominal rate is 2400 bit/s. The one-shot width follows from the parameters for system clock frequency and bit rate.

Top module: `tape_codec`

## Requirements
- R1: `line_out` equals `tx_data` XOR `tx_bitclk` as sampled at the previous rising clock edge, so it is registered with one cycle of latency.
- R2: While `rst_n` is low, and in the first cycle after it is released, `line_out`, `rx_data` and `os_busy` are all 0.
- R3: A rising or a falling transition on `rx_line` starts the one-shot. The line passes a two-flop synchronizer and an edge-compare flop, so `os_busy` goes high after the third rising clock edge following the change.
- R4: The one-shot stays high for exactly OS_CYCLES = floor(3 × (SYS_CLK_HZ / BIT_RATE) / 4) system clock cycles, provided no further transition arrives.
- R5: A transition detected while the one-shot is high restarts the full OS_CYCLES interval. Nothing is latched at the earlier expiry point, and `os_busy` stays high throughout.
- R6: `rx_data` changes only on the clock edge where the one-shot expires. At that edge it takes the synchronized level of `rx_line`. Otherwise it holds its value.
- R7: With `tx_bitclk` low in the first half of each bit cell and `line_out` looped to `rx_line`, `rx_data` equals the transmitted bit from about a quarter cell into each bit until the end of that bit. This holds for alternating bits, for long runs of ones or zeros, and for mixed patterns. The stream must open with a 1 followed by a 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_data | input | 1 | Serial data to be encoded |
| tx_bitclk | input | 1 | Bit-rate square wave, low in the first half of a cell |
| line_out | output | 1 | Coded line to the tape channel |
| rx_line | input | 1 | Coded line from playback, asynchronous |
| rx_data | output | 1 | Recovered serial data |
| os_busy | output | 1 | One-shot timer running |

## Verification
The bench builds the block with SYS_CLK_HZ = 153600 and BIT_RATE = 2400. That gives 64 system clocks per bit and a one-shot of 48 cycles. With these values a full bit is short enough that streams of forty bits, including runs of twenty or more identical bits, fit easily in the run time. The 48-cycle timer sits well apart from both the half-cell retrigger spacing of 32 cycles and the full-cell gap of 64 cycles. As a result, both the retrigger path and the expiry path are exercised on every pattern, and the exact width can be counted cycle by cycle.

// File: rtl/tape_codec_pkg.sv
package tape_codec_pkg;

    // One-shot timer states
    typedef enum logic {
        OS_IDLE = 1'b0,   // waiting for a line transition
        OS_HOLD = 1'b1    // timing the three-quarter-cell window
    } os_state_t;

endpackage

// File: rtl/tc_encoder.sv
module tc_encoder (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_data,
    input  logic tx_bitclk,
    output logic line_out
);

    logic coded_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            coded_q <= 1'b0;
        end else begin
            coded_q <= tx_data ^ tx_bitclk;
        end
    end

    assign line_out = coded_q;

endmodule

// File: rtl/tc_edge_detect.sv
module tc_edge_detect #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_line,
    output logic line_sync,
    output logic edge_p
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= rx_line;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[SYNC_STAGES-1];
    end

    assign line_sync = sync_q[SYNC_STAGES-1];
    assign edge_p    = sync_q[SYNC_STAGES-1] ^ prev_q;

endmodule

// File: rtl/tc_oneshot.sv
module tc_oneshot
    import tape_codec_pkg::*;
#(
    parameter int OS_CYCLES = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic busy,
    output logic fire
);

    localparam int CW = $clog2(OS_CYCLES + 1);

    os_state_t      state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= OS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Transitions: any trigger (re)loads the window; HOLD counts down to expiry
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        fire    = 1'b0;
        if (trig) begin
            state_d = OS_HOLD;
            cnt_d   = CW'(OS_CYCLES - 1);
        end else begin
            unique case (state_q)
                OS_IDLE: begin
                    state_d = OS_IDLE;
                end
                OS_HOLD: begin
                    if (cnt_q == '0) begin
                        state_d = OS_IDLE;
                        fire    = 1'b1;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
                default: state_d = OS_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        busy = (state_q == OS_HOLD);
    end

endmodule

// File: rtl/tc_data_latch.sv
module tc_data_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic din,
    output logic dout
);

    logic data_q;

    always_ff @(posedge clk) begin
        if (!rst_n)    data_q <= 1'b0;
        else if (load) data_q <= din;
    end

    assign dout = data_q;

endmodule

// File: rtl/tape_codec.sv
module tape_codec #(
    parameter int SYS_CLK_HZ  = 1228800,
    parameter int BIT_RATE    = 2400,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_data,
    input  logic tx_bitclk,
    output logic line_out,
    input  logic rx_line,
    output logic rx_data,
    output logic os_busy
);

    localparam int CLK_PER_BIT = SYS_CLK_HZ / BIT_RATE;
    localparam int OS_CYCLES   = (3 * CLK_PER_BIT) / 4;

    logic line_sync;
    logic edge_p;
    logic os_fire;

    tc_encoder u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_data   (tx_data),
        .tx_bitclk (tx_bitclk),
        .line_out  (line_out)
    );

    tc_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_line   (rx_line),
        .line_sync (line_sync),
        .edge_p    (edge_p)
    );

    tc_oneshot #(.OS_CYCLES(OS_CYCLES)) u_os (
        .clk   (clk),
        .rst_n (rst_n),
        .trig  (edge_p),
        .busy  (os_busy),
        .fire  (os_fire)
    );

    tc_data_latch u_lat (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (os_fire),
        .din   (line_sync),
        .dout  (rx_data)
    );

endmodule

// File: rtl/tape_codec_chk.sv
module tape_codec_chk #(
    parameter int OS_CYCLES = 48
) (
    input logic clk,
    input logic rst_n,
    input logic tx_data,
    input logic tx_bitclk,
    input logic line_out,
    input logic edge_p,
    input logic os_busy,
    input logic rx_data
);

    localparam int LW = $clog2(OS_CYCLES + 2) + 1;

    logic [LW-1:0] run_len;

    // Cycles of busy since the last detected transition
    always_ff @(posedge clk) begin
        if (!rst_n)                       run_len <= '0;
        else if (edge_p)                  run_len <= '0;
        else if (os_busy && !(&run_len))  run_len <= run_len + 1'b1;
    end

    a_r1_encode: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (line_out == ($past(tx_data) ^ $past(tx_bitclk))));

    a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
        edge_p |=> os_busy);

    a_r5_retrigger: assert property (@(posedge clk) disable iff (!rst_n)
        (os_busy && edge_p) |=> (os_busy && $stable(rx_data)));

    a_r4_width: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $fell(os_busy)) |-> (run_len == LW'(OS_CYCLES)));

    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$fell(os_busy)) |-> $stable(rx_data));

endmodule

bind tape_codec tape_codec_chk #(.OS_CYCLES(OS_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_data   (tx_data),
    .tx_bitclk (tx_bitclk),
    .line_out  (line_out),
    .edge_p    (edge_p),
    .os_busy   (os_busy),
    .rx_data   (rx_data)
);

// File: tb/sim_tape_codec.sv
module sim_tape_codec;

    localparam int CLK_PERIOD = 10;
    localparam int SYS_HZ     = 153600;
    localparam int BAUD       = 2400;
    localparam int CPB        = SYS_HZ / BAUD;    // 64
    localparam int OS_EXP     = (3 * CPB) / 4;    // 48

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_data = 1'b0;
    logic tx_bitclk = 1'b0;
    logic line_out;
    logic rx_man = 1'b0;
    logic loop_en = 1'b0;
    logic rx_line;
    logic rx_data;
    logic os_busy;

    int tests = 0;
    int fails = 0;
    logic [15:0] lfsr = 16'hACE1;

    assign rx_line = loop_en ? line_out : rx_man;

    always #(CLK_PERIOD/2) clk = ~clk;

    tape_codec #(.SYS_CLK_HZ(SYS_HZ), .BIT_RATE(BAUD), .SYNC_STAGES(2)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_data   (tx_data),
        .tx_bitclk (tx_bitclk),
        .line_out  (line_out),
        .rx_line   (rx_line),
        .rx_data   (rx_data),
        .os_busy   (os_busy)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
    endtask

    // R2: reset state
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R2 line_out in reset", line_out, 0);
        check("R2 rx_data in reset", rx_data, 0);
        check("R2 os_busy in reset", os_busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 line_out after release", line_out, 0);
        check("R2 os_busy after release", os_busy, 0);
    endtask

    // R1: XOR encoding, one cycle latency
    task automatic t_encode();
        for (int k = 0; k < 4; k++) begin
            tx_data   = k[1];
            tx_bitclk = k[0];
            @(negedge clk);
            check("R1 line_out", line_out, int'(k[1] ^ k[0]));
        end
        tx_data = 1'b0;
        tx_bitclk = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // R3, R4, R6: one transition, width and latched level
    task automatic t_single(input logic lvl);
        int cnt;
        logic old;
        old = rx_data;
        rx_man = lvl;
        @(negedge clk);
        @(negedge clk);
        check("R3 busy not yet high", os_busy, 0);
        @(negedge clk);
        check("R3 busy after sync", os_busy, 1);
        check("R6 rx_data held while busy", rx_data, old);
        cnt = 1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (!os_busy) break;
            cnt++;
        end
        check("R4 one-shot width", cnt, OS_EXP);
        check("R6 rx_data at expiry", rx_data, lvl);
        repeat (5) @(negedge clk);
        check("R6 rx_data stays", rx_data, lvl);
    endtask

    // R5: retrigger inside the window
    task automatic t_retrigger();
        rx_man = 1'b1;
        repeat (40) @(negedge clk);
        rx_man = 1'b0;
        repeat (40) @(negedge clk);
        check("R5 busy after 80 cycles", os_busy, 1);
        check("R5 no latch at first expiry", rx_data, 0);
        rx_man = 1'b1;
        repeat (40) @(negedge clk);
        check("R5 busy still high", os_busy, 1);
        check("R5 rx_data still old", rx_data, 0);
        repeat (OS_EXP + 4) @(negedge clk);
        check("R5 idle after last window", os_busy, 0);
        check("R5 final latch", rx_data, 1);
        rx_man = 1'b0;
        repeat (OS_EXP + 8) @(negedge clk);
    endtask

    function automatic logic pick_bit(input int kind, input int idx);
        logic b;
        if (idx == 0) return 1'b1;
        if (idx == 1) return 1'b0;
        case (kind)
            0: b = idx[0];
            1: b = (idx < 24) ? 1'b1 : ((idx < 44) ? 1'b0 : idx[0]);
            default: begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                b = lfsr[0];
            end
        endcase
        return b;
    endfunction

    // R7: loopback stream recovery
    task automatic t_stream(input int kind, input int nbits);
        logic b;
        loop_en = 1'b1;
        for (int i = 0; i < nbits; i++) begin
            b = pick_bit(kind, i);
            for (int c = 0; c < CPB; c++) begin
                if (c == 60 && i >= 2)
                    check($sformatf("R7 stream %0d bit %0d", kind, i), rx_data, b);
                tx_data   = b;
                tx_bitclk = (c >= CPB / 2);
                @(negedge clk);
            end
        end
        tx_data = 1'b0;
        tx_bitclk = 1'b0;
        repeat (2 * CPB) @(negedge clk);
        loop_en = 1'b0;
        rx_man = line_out;
        repeat (2 * CPB) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_encode();
        t_single(1'b1);
        t_single(1'b0);
        t_retrigger();
        t_stream(0, 40);
        t_stream(1, 60);
        t_stream(2, 60);
        summary();
        $finish;
    end

endmodule